// File: doc/BRIEF.md
# Triggered Single-Channel DMA Engine

This block is one DMA channel that shares a single address and data bus with a CPU. Software sets a source address, a destination address, an item count and a control word. A selected external trigger then makes the channel ask the CPU to stall. Once the CPU grants the bus, the channel moves bytes or words by itself. Each item takes one read cycle and then one write cycle. The synchronous memory returns read data on the cycle after the address.

The channel never asks for the bus while it waits for a trigger, so the CPU runs at full speed between transfers. There are three transfer modes:

- **Single:** each trigger moves one item.
- **Block:** one trigger moves the whole count while the CPU stays stalled.
- **Burst:** one trigger moves the whole count, but the bus goes back to the CPU for a few cycles after every item.

A repeat bit makes the channel reload its original addresses and count at the end of a count and stay armed. A protection bit keeps the channel off the bus while the CPU is part-way through a read-modify-write.

Top module: `dma_chan`

## Requirements
- R1: The channel drives the bus (`m_own`) only while `cpu_hold` and `bus_grant` are both high. `cpu_hold` rises at least one cycle before the first bus cycle, `m_rd` and `m_we` are never both high, and the bus is released on the cycle after a write.
- R2: While the channel is enabled but no trigger is pending, `cpu_hold` stays low.
- R3: A rising edge on `trig_in[s]` starts service only when the channel is enabled and s equals the control bits [10:9]. Edges on other inputs, and edges while the channel is disabled, are ignored.
- R4: Single mode (control bits [4:3] = 0) moves exactly one item per trigger. Every item is a read of the source address followed on the next cycle by a write of that data to the destination address.
- R5: Block mode ([4:3] = 1) moves the whole count after one trigger. It uses exactly two bus cycles per item with one unbroken `cpu_hold` assertion.
- R6: Burst mode ([4:3] = 2) moves the whole count after one trigger. `cpu_hold` drops for at least one cycle between items, so there is one hold assertion per item.
- R7: Each side steps by its own control bit: bit 7 for the source and bit 8 for the destination. A set bit advances that address by 2 in word mode or by 1 in byte mode (bit 6 set). A clear bit holds that address constant. Byte items move only the low byte.
- R8: With repeat set (bit 5), the end of a count reloads the originally written source, destination and count, and the channel stays enabled and armed.
- R9: Without repeat, the enable bit (control bit 0, seen on `ch_enabled`) clears itself at the end of the count.
- R10: With control bit 11 set, `cpu_hold` does not rise while `rmw_busy` is high. Service starts after `rmw_busy` falls.
- R11: The end of a count sets the `done_flag` (control bit 2, cleared by writing 0). `irq` follows `done_flag` only when the interrupt enable (bit 1) is set.
- R12: A trigger edge that arrives while a transfer is running is held as one pending request. Several such edges merge into that single request.

Register map (`cfg_addr`): 0 = control word, 1 = source address, 2 = destination address, 3 = item count. Setting enable from 0 loads the working addresses and count from the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| trig_in | input | 4 | External trigger inputs |
| rmw_busy | input | 1 | CPU is inside a read-modify-write |
| bus_grant | input | 1 | CPU has stalled and granted the bus |
| cpu_hold | output | 1 | Request to stall the CPU |
| m_own | output | 1 | Channel is driving the bus this cycle |
| m_addr | output | 16 | Bus address |
| m_rd | output | 1 | Bus read strobe |
| m_we | output | 1 | Bus write strobe |
| m_byte | output | 1 | Byte-wide access |
| m_wdata | output | 16 | Bus write data |
| m_rdata | input | 16 | Bus read data, valid one cycle after `m_rd` |
| ch_enabled | output | 1 | Current state of the enable bit |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is a trigger edge that lands while a transfer is already on the bus. Close behind it is the case where several such edges must merge. The bench arms a repeating block transfer and polls `m_own` until the channel holds the bus. It then fires two trigger pulses while the block is still running, and counts the writes to show that exactly one more block follows. The read-modify-write deferral is reached by holding `rmw_busy` high across a trigger and checking that no hold request appears until `rmw_busy` drops.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_RD,
    ST_WR,
    ST_GAP
  } dma_state_t;

  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_BLOCK  = 2'd1,
    XM_BURST  = 2'd2
  } xfer_mode_t;

  typedef struct packed {
    logic       en;
    logic       ie;
    xfer_mode_t mode;
    logic       rpt;
    logic       bytem;
    logic       sinc;
    logic       dinc;
    logic       rmwp;
  } ctl_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 16,
  parameter int TSW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              set_done,
  input  logic              clr_en,
  output dma_pkg::ctl_t     ctl,
  output logic [TSW-1:0]    tsel,
  output logic [AW-1:0]     org_src,
  output logic [AW-1:0]     org_dst,
  output logic [CW-1:0]     org_cnt,
  output logic              done_flag,
  output logic              irq,
  output logic              en_load
);
  import dma_pkg::*;
  localparam int TS_LO   = 9;
  localparam int RMW_BIT = TS_LO + TSW;

  assign en_load = cfg_we && (cfg_addr == 2'd0) && cfg_wdata[0] && !ctl.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      tsel      <= '0;
      org_src   <= '0;
      org_dst   <= '0;
      org_cnt   <= '0;
      done_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: begin
            ctl.en    <= cfg_wdata[0];
            ctl.ie    <= cfg_wdata[1];
            done_flag <= cfg_wdata[2];
            ctl.mode  <= xfer_mode_t'(cfg_wdata[4:3]);
            ctl.rpt   <= cfg_wdata[5];
            ctl.bytem <= cfg_wdata[6];
            ctl.sinc  <= cfg_wdata[7];
            ctl.dinc  <= cfg_wdata[8];
            tsel      <= cfg_wdata[TS_LO +: TSW];
            ctl.rmwp  <= cfg_wdata[RMW_BIT];
          end
          2'd1: org_src <= cfg_wdata[AW-1:0];
          2'd2: org_dst <= cfg_wdata[AW-1:0];
          default: org_cnt <= cfg_wdata[CW-1:0];
        endcase
      end
      if (clr_en)   ctl.en    <= 1'b0;
      if (set_done) done_flag <= 1'b1;
      irq <= done_flag && ctl.ie;
    end
  end
endmodule

// File: rtl/dma_trig.sv
module dma_trig #(
  parameter int NTRIG = 4,
  parameter int TSW   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [TSW-1:0]   tsel,
  input  logic             enable,
  input  logic             consume,
  output logic             pending
);
  logic [NTRIG-1:0] trig_q;
  logic [NTRIG-1:0] edge_v;
  logic             evt;

  for (genvar g = 0; g < NTRIG; g++) begin : g_edge
    assign edge_v[g] = trig_in[g] && !trig_q[g];
  end

  assign evt = edge_v[tsel];

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q  <= '0;
      pending <= 1'b0;
    end else begin
      trig_q <= trig_in;
      if (!enable)      pending <= 1'b0;
      else if (evt)     pending <= 1'b1;
      else if (consume) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_addr.sv
module dma_addr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          sinc,
  input  logic          dinc,
  input  logic          bytem,
  input  logic [AW-1:0] org_src,
  input  logic [AW-1:0] org_dst,
  input  logic [CW-1:0] org_cnt,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic          last
);
  logic [CW-1:0] cur_cnt;
  logic [AW-1:0] stride;

  assign stride = bytem ? AW'(1) : AW'(2);
  assign last   = (cur_cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_src <= '0;
      cur_dst <= '0;
      cur_cnt <= '0;
    end else if (load) begin
      cur_src <= org_src;
      cur_dst <= org_dst;
      cur_cnt <= org_cnt;
    end else if (step) begin
      if (sinc) cur_src <= cur_src + stride;
      if (dinc) cur_dst <= cur_dst + stride;
      cur_cnt <= cur_cnt - CW'(1);
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int GAP = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  dma_pkg::xfer_mode_t mode,
  input  logic               rpt,
  input  logic               rmwp,
  input  logic               rmw_busy,
  input  logic               pend,
  input  logic               grant,
  input  logic               last,
  output logic               consume,
  output logic               cpu_hold,
  output logic               own,
  output logic               rd,
  output logic               we,
  output logic               step,
  output logic               reload,
  output logic               set_done,
  output logic               clr_en
);
  import dma_pkg::*;
  localparam int GW = $clog2(GAP + 1);

  dma_state_t      st;
  logic [GW-1:0]   gcnt;
  logic            blocked;

  assign blocked  = rmwp && rmw_busy;
  assign consume  = (st == ST_IDLE) && en && pend && !blocked;
  assign cpu_hold = (st == ST_ARB) || (st == ST_RD) || (st == ST_WR);
  assign rd       = (st == ST_RD);
  assign we       = (st == ST_WR);
  assign own      = rd || we;
  assign step     = we && !last;
  assign reload   = we && last && rpt;
  assign set_done = we && last;
  assign clr_en   = we && last && !rpt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      gcnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (consume) st <= ST_ARB;
        ST_ARB:  if (grant) st <= ST_RD;
        ST_RD:   st <= ST_WR;
        ST_WR: begin
          if (last) st <= ST_IDLE;
          else begin
            case (mode)
              XM_BLOCK: st <= ST_RD;
              XM_BURST: begin
                st   <= ST_GAP;
                gcnt <= '0;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
        ST_GAP: begin
          if (gcnt >= GW'(GAP - 1)) begin
            if (!blocked) st <= ST_ARB;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int NTRIG = 4,
  parameter int GAP   = 3,
  localparam int TSW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             rmw_busy,
  input  logic             bus_grant,
  output logic             cpu_hold,
  output logic             m_own,
  output logic [AW-1:0]    m_addr,
  output logic             m_rd,
  output logic             m_we,
  output logic             m_byte,
  output logic [DW-1:0]    m_wdata,
  input  logic [DW-1:0]    m_rdata,
  output logic             ch_enabled,
  output logic             done_flag,
  output logic             irq
);
  import dma_pkg::*;

  ctl_t           ctl;
  logic [TSW-1:0] tsel;
  logic [AW-1:0]  org_src, org_dst, cur_src, cur_dst;
  logic [CW-1:0]  org_cnt;
  logic           en_load, set_done, clr_en, consume, pend;
  logic           step, reload, last, rmw_prot;

  assign rmw_prot   = ctl.rmwp;
  assign ch_enabled = ctl.en;

  dma_regs #(.AW(AW), .CW(CW), .DW(DW), .TSW(TSW)) u_regs (
    .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata,
    .set_done, .clr_en, .ctl, .tsel,
    .org_src, .org_dst, .org_cnt,
    .done_flag, .irq, .en_load
  );

  dma_trig #(.NTRIG(NTRIG), .TSW(TSW)) u_trig (
    .clk, .rst, .trig_in, .tsel,
    .enable(ctl.en), .consume, .pending(pend)
  );

  dma_addr #(.AW(AW), .CW(CW)) u_addr (
    .clk, .rst,
    .load(en_load || reload), .step,
    .sinc(ctl.sinc), .dinc(ctl.dinc), .bytem(ctl.bytem),
    .org_src, .org_dst, .org_cnt,
    .cur_src, .cur_dst, .last
  );

  dma_seq #(.GAP(GAP)) u_seq (
    .clk, .rst,
    .en(ctl.en), .mode(ctl.mode), .rpt(ctl.rpt),
    .rmwp(ctl.rmwp), .rmw_busy, .pend,
    .grant(bus_grant), .last,
    .consume, .cpu_hold, .own(m_own),
    .rd(m_rd), .we(m_we),
    .step, .reload, .set_done, .clr_en
  );

  assign m_addr  = m_rd ? cur_src : cur_dst;
  assign m_byte  = ctl.bytem;
  assign m_wdata = m_rdata;
endmodule

// File: rtl/dma_chan_checks.sv
module dma_chan_checks (
  input logic clk,
  input logic rst,
  input logic cpu_hold,
  input logic bus_grant,
  input logic m_own,
  input logic m_rd,
  input logic m_we,
  input logic rmw_busy,
  input logic rmw_prot
);
  assert_owner_granted_R1: assert property (@(posedge clk) disable iff (rst)
    m_own |-> (cpu_hold && bus_grant));

  assert_hold_leads_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_hold) |-> !m_own);

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(m_rd && m_we));

  assert_release_after_write_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(m_own) |-> $past(m_we));

  assert_read_before_write_R4: assert property (@(posedge clk) disable iff (rst)
    m_we |-> $past(m_rd));

  assert_rmw_defer_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_hold) |-> !($past(rmw_busy) && $past(rmw_prot)));
endmodule

bind dma_chan dma_chan_checks u_checks (
  .clk(clk), .rst(rst), .cpu_hold(cpu_hold), .bus_grant(bus_grant),
  .m_own(m_own), .m_rd(m_rd), .m_we(m_we),
  .rmw_busy(rmw_busy), .rmw_prot(rmw_prot)
);

// File: tb/dma_chan_test.sv
module dma_chan_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  trig_in = '0;
  logic        rmw_busy = 1'b0;
  logic        bus_grant;
  logic        cpu_hold, m_own, m_rd, m_we, m_byte;
  logic [15:0] m_addr, m_wdata, m_rdata;
  logic        ch_enabled, done_flag, irq;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  int own_cnt = 0;
  int rise_cnt = 0;
  logic hold_q = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] shadow [256];

  always #2 clk = ~clk;

  dma_chan uut (
    .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .trig_in, .rmw_busy,
    .bus_grant, .cpu_hold, .m_own, .m_addr, .m_rd, .m_we, .m_byte,
    .m_wdata, .m_rdata, .ch_enabled, .done_flag, .irq
  );

  // CPU grant model and synchronous memory
  always_ff @(posedge clk) begin
    bus_grant <= rst ? 1'b0 : cpu_hold;
    if (m_rd)
      m_rdata <= m_byte ? {8'h00, mem[m_addr[7:0]]}
                        : {mem[m_addr[7:0] + 8'd1], mem[m_addr[7:0]]};
    if (m_we) begin
      mem[m_addr[7:0]] <= m_wdata[7:0];
      if (!m_byte) mem[m_addr[7:0] + 8'd1] <= m_wdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    hold_q <= cpu_hold;
    if (m_we) we_cnt <= we_cnt + 1;
    if (m_own) own_cnt <= own_cnt + 1;
    if (cpu_hold && !hold_q) rise_cnt <= rise_cnt + 1;
  end

  // {ie, mode[1:0], byte, sinc, dinc, src[7:0], dst[7:0], size[3:0], tsel[1:0]}
  localparam int NV = 6;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h80, 4'd3, 2'd0},
    {1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 8'h20, 8'h90, 4'd4, 2'd1},
    {1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 8'h40, 8'hA0, 4'd3, 2'd2},
    {1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 8'h30, 8'hB0, 4'd4, 2'd3},
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 8'h50, 8'hB4, 4'd2, 2'd0},
    {1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 8'h60, 8'hBA, 4'd5, 2'd1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] mk_ctl(input bit en, input bit ie, input logic [1:0] md,
      input bit rp, input bit by, input bit si, input bit di, input logic [1:0] ts, input bit rw);
    return {4'b0, rw, ts, di, si, by, rp, md, 1'b0, ie, en};
  endfunction

  task automatic pulse(input int idx);
    @(negedge clk); trig_in[idx] = 1'b1;
    @(negedge clk); trig_in[idx] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shadow_xfer(input logic [7:0] s, input logic [7:0] d, input int n,
      input bit by, input bit si, input bit di);
    for (int k = 0; k < n; k++) begin
      logic [7:0] sa, da;
      sa = s + (si ? 8'(k * (by ? 1 : 2)) : 8'd0);
      da = d + (di ? 8'(k * (by ? 1 : 2)) : 8'd0);
      shadow[da] = mem[sa];
      if (!by) shadow[da + 8'd1] = mem[sa + 8'd1];
    end
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 37 + 11) ^ 8'h5A);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!cpu_hold && !m_own && !irq && !done_flag && !ch_enabled,
          "reset R1", int'(cpu_hold), 0);

    // table walk: R4 R5 R6 R7 R9 R11
    for (int v = 0; v < NV; v++) begin
      logic [27:0] t;
      int n, w0, o0, r0, expr;
      t = VEC[v];
      n = int'(t[5:2]);
      shadow_xfer(t[21:14], t[13:6], n, t[24], t[23], t[22]);
      wr(2'd1, {8'h00, t[21:14]});
      wr(2'd2, {8'h00, t[13:6]});
      wr(2'd3, 16'(n));
      w0 = we_cnt; o0 = own_cnt; r0 = rise_cnt;
      wr(2'd0, mk_ctl(1, t[27], t[26:25], 0, t[24], t[23], t[22], t[1:0], 0));
      if (t[26:25] == 2'd0) begin
        for (int k = 0; k < n; k++) begin
          pulse(int'(t[1:0]));
          idle(12);
          check(we_cnt - w0 == k + 1, "single one item per trigger R4", we_cnt - w0, k + 1);
        end
      end else begin
        pulse(int'(t[1:0]));
        idle(12 * n + 10);
      end
      cmp_mem("memory image R7");
      check(we_cnt - w0 == n, "item count R4", we_cnt - w0, n);
      check(own_cnt - o0 == 2 * n, "two cycles per item R5", own_cnt - o0, 2 * n);
      expr = (t[26:25] == 2'd1) ? 1 : n;
      check(rise_cnt - r0 == expr, "hold assertions per mode R5 R6", rise_cnt - r0, expr);
      check(!ch_enabled, "enable self-clear R9", int'(ch_enabled), 0);
      check(done_flag, "done flag R11", int'(done_flag), 1);
      check(irq == t[27], "irq gated by enable R11", int'(irq), int'(t[27]));
      wr(2'd0, 16'h0000);
      idle(2);
      check(!done_flag && !irq, "flag clear R11", int'(done_flag), 0);
    end

    // R2: armed, no trigger
    begin
      int r0;
      wr(2'd1, 16'h0010); wr(2'd2, 16'h00C8); wr(2'd3, 16'd1);
      r0 = rise_cnt;
      wr(2'd0, mk_ctl(1, 0, 2'd0, 0, 0, 1, 1, 2'd1, 0));
      idle(30);
      check(rise_cnt == r0 && !cpu_hold, "armed idle no hold R2", rise_cnt - r0, 0);
      // R3: wrong trigger input ignored
      pulse(2); pulse(0); pulse(3);
      idle(15);
      check(rise_cnt == r0, "unselected trigger ignored R3", rise_cnt - r0, 0);
      shadow_xfer(8'h10, 8'hC8, 1, 0, 1, 1);
      pulse(1);
      idle(15);
      check(rise_cnt - r0 == 1, "selected trigger served R3", rise_cnt - r0, 1);
      cmp_mem("selected trigger data R3");
      wr(2'd0, 16'h0000);
      // R3: disabled channel ignores trigger
      r0 = we_cnt;
      pulse(1);
      idle(15);
      check(we_cnt == r0 && !cpu_hold, "disabled trigger ignored R3", we_cnt - r0, 0);
      cmp_mem("disabled memory untouched R3");
    end

    // R10: read-modify-write deferral
    begin
      int r0;
      wr(2'd1, 16'h0012); wr(2'd2, 16'h00CA); wr(2'd3, 16'd1);
      wr(2'd0, mk_ctl(1, 0, 2'd0, 0, 0, 1, 1, 2'd0, 1));
      r0 = rise_cnt;
      @(negedge clk); rmw_busy = 1'b1;
      pulse(0);
      idle(15);
      check(rise_cnt == r0, "no hold during rmw R10", rise_cnt - r0, 0);
      shadow_xfer(8'h12, 8'hCA, 1, 0, 1, 1);
      rmw_busy = 1'b0;
      idle(15);
      check(rise_cnt - r0 == 1, "served after rmw R10", rise_cnt - r0, 1);
      cmp_mem("rmw transfer data R10");
      wr(2'd0, 16'h0000);
    end

    // R8: repeated single, size 2, three triggers
    begin
      wr(2'd1, 16'h0014); wr(2'd2, 16'h00C0); wr(2'd3, 16'd2);
      wr(2'd0, mk_ctl(1, 1, 2'd0, 1, 0, 1, 1, 2'd2, 0));
      shadow_xfer(8'h14, 8'hC0, 2, 0, 1, 1);
      pulse(2); idle(12);
      pulse(2); idle(12);
      check(ch_enabled && done_flag, "repeat stays armed R8", int'(ch_enabled), 1);
      mem[8'hC0] = 8'h00; shadow[8'hC0] = 8'h00;
      mem[8'hC1] = 8'h00; shadow[8'hC1] = 8'h00;
      shadow_xfer(8'h14, 8'hC0, 1, 0, 1, 1);
      pulse(2); idle(12);
      cmp_mem("repeat reload addresses R8");
      wr(2'd0, 16'h0000);
    end

    // R12: triggers during a running block merge into one request
    begin
      int w0, r0;
      wr(2'd1, 16'h0018); wr(2'd2, 16'h00D0); wr(2'd3, 16'd3);
      w0 = we_cnt; r0 = rise_cnt;
      wr(2'd0, mk_ctl(1, 0, 2'd1, 1, 0, 1, 1, 2'd3, 0));
      pulse(3);
      while (!m_own) @(negedge clk);
      trig_in[3] = 1'b1; @(negedge clk);
      trig_in[3] = 1'b0; @(negedge clk);
      trig_in[3] = 1'b1; @(negedge clk);
      trig_in[3] = 1'b0;
      idle(40);
      check(we_cnt - w0 == 6, "merged pending one extra block R12", we_cnt - w0, 6);
      check(rise_cnt - r0 == 2, "two hold periods R12", rise_cnt - r0, 2);
      wr(2'd0, 16'h0000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule